// File: doc/BRIEF.md
# Settable Minute-Second Countdown Timer

This block is the core of a kitchen-style countdown timer. It keeps a time value as four BCD digits, minutes then seconds, and has two modes. In SET mode, the up and down buttons choose a whole number of minutes. In GO mode, the value falls by one second on each tick of an internal divider. A single centre button flips between the two modes. Entering SET keeps the current seconds, so the same button pauses and resumes a running count.

The three button inputs are raw levels. Each one passes through its own synchroniser and rising-edge detector, so a press of any length yields exactly one action. The outputs are the four BCD digits, a flag that shows GO mode, and an enable for the decimal point that sits after the minutes units digit. A downstream display driver turns these into segments.

Top module: `countdown_timer`

## Requirements
- R1: After reset the block is in SET mode (modeGo = 0) and shows 00:00, with all four digits zero.
- R2: Each press of the centre button toggles modeGo. The change appears on the third rising clock edge after the raw level rises.
- R3: In SET mode with seconds at 00, a press of up adds exactly one minute. At the ceiling of 60:00 it leaves the value unchanged.
- R4: In SET mode with seconds at 00, a press of down removes exactly one minute. At 00:00 it leaves the value unchanged.
- R5: In SET mode with nonzero seconds, up moves to the next whole minute (mm:ss becomes mm+1:00) and down drops the seconds (mm:ss becomes mm:00).
- R6: In GO mode the value falls by one second every TICK_DIV cycles. The first decrement comes TICK_DIV cycles after GO is entered. Seconds 00 borrow a minute and become 59.
- R7: In GO mode a value of 00:00 holds and never wraps.
- R8: Entering SET keeps the current minutes and seconds unchanged. Going back to GO continues the count from that held value.
- R9: Presses of up or down while in GO mode have no effect on the value.
- R10: Holding a button for many cycles causes exactly one action.
- R11: The digits are always legal: seconds tens 0..5, every units digit 0..9, and the minutes never above 60.
- R12: The decimal-point enable for the minutes units digit is always high, so the value reads MM.SS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btnCentreRaw | input | 1 | Raw level of the mode (pause/resume) button |
| btnUpRaw | input | 1 | Raw level of the minute-up button |
| btnDownRaw | input | 1 | Raw level of the minute-down button |
| minTens | output | 4 | BCD minutes tens digit |
| minUnits | output | 4 | BCD minutes units digit |
| secTens | output | 4 | BCD seconds tens digit |
| secUnits | output | 4 | BCD seconds units digit |
| modeGo | output | 1 | 1 in GO mode, 0 in SET mode |
| dpMinUnits | output | 1 | Decimal-point enable after the minutes units digit |

## Verification
A button action passes through two synchroniser flops and the edge register, so its effect on the digits or on modeGo appears on the third rising edge after the raw level changes. The bench drives inputs on falling edges and samples exactly three falling edges later. A countdown decrement lands TICK_DIV cycles after the mode change and then every TICK_DIV cycles after that. For each tick the bench checks that the old value is still present one cycle before the due edge and that the new value is present just after it. All expected times are kept as a plain count of seconds and split into digits arithmetically.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  typedef enum logic {
    MODE_SET = 1'b0,
    MODE_GO  = 1'b1
  } timerMode_t;

  // strobes from control to datapath, at most one of stepUp/stepDown/tick active
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic tick;
  } ctrlStrobes_t;

  localparam int unsigned DIGIT_W = 4;

endpackage

// File: rtl/ctimer_btn_sync.sv
module ctimer_btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic pressEdge
);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], rawIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign pressEdge = syncQ[STAGES-1] & ~prevQ;

  // R10: an edge lasts one cycle only
  p_one_edge_r10: assert property (@(posedge clk) disable iff (rst)
    pressEdge |=> !pressEdge);

endmodule

// File: rtl/ctimer_tick_div.sv
module ctimer_tick_div #(
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic tickPulse
);

  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cntQ;

  // counter parks at zero outside GO, so every entry into GO starts a full period
  always_ff @(posedge clk) begin
    if (rst || !enable)   cntQ <= '0;
    else if (cntQ == LAST) cntQ <= '0;
    else                   cntQ <= cntQ + 1'b1;
  end

  assign tickPulse = enable && (cntQ == LAST);

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R6: pulses are never back to back
      p_pulse_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        tickPulse |=> !tickPulse);
    end
  endgenerate

endmodule

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         centreEdge,
  input  logic         upEdge,
  input  logic         downEdge,
  input  logic         tickPulse,
  output ctrlStrobes_t strobes,
  output logic         modeGo
);

  timerMode_t modeQ;

  always_ff @(posedge clk) begin
    if (rst)             modeQ <= MODE_SET;
    else if (centreEdge) modeQ <= (modeQ == MODE_SET) ? MODE_GO : MODE_SET;
  end

  assign modeGo = (modeQ == MODE_GO);

  // up wins over down if both land together; a tick coinciding with a pause is dropped
  always_comb begin
    strobes          = '0;
    strobes.stepUp   = !modeGo && upEdge;
    strobes.stepDown = !modeGo && downEdge && !upEdge;
    strobes.tick     = modeGo && tickPulse && !centreEdge;
  end

  // R2: centre edge flips the mode
  p_toggle_flips_r2: assert property (@(posedge clk) disable iff (rst)
    centreEdge |=> (modeQ != $past(modeQ)));

  // R9: without a centre edge the mode is held
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !centreEdge |=> $stable(modeQ));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(strobes) <= 1);

endmodule

// File: rtl/ctimer_datapath.sv
module ctimer_datapath
  import ctimer_pkg::*;
#(
  parameter int unsigned MAX_MINUTES = 60
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  output logic [DIGIT_W-1:0] minTens,
  output logic [DIGIT_W-1:0] minUnits,
  output logic [DIGIT_W-1:0] secTens,
  output logic [DIGIT_W-1:0] secUnits
);

  localparam logic [DIGIT_W-1:0] MAX_T = DIGIT_W'(MAX_MINUTES / 10);
  localparam logic [DIGIT_W-1:0] MAX_U = DIGIT_W'(MAX_MINUTES % 10);

  logic [DIGIT_W-1:0] minTQ, minUQ, secTQ, secUQ;
  logic [DIGIT_W-1:0] minTD, minUD, secTD, secUD;
  logic secZero, minZero, atMax;

  assign secZero = (secTQ == '0) && (secUQ == '0);
  assign minZero = (minTQ == '0) && (minUQ == '0);
  assign atMax   = (minTQ == MAX_T) && (minUQ == MAX_U);

  always_comb begin
    minTD = minTQ;
    minUD = minUQ;
    secTD = secTQ;
    secUD = secUQ;
    if (strobes.stepUp) begin
      secTD = '0;
      secUD = '0;
      if (!atMax) begin
        if (minUQ == 4'd9) begin
          minUD = '0;
          minTD = minTQ + 1'b1;
        end else begin
          minUD = minUQ + 1'b1;
        end
      end
    end else if (strobes.stepDown) begin
      secTD = '0;
      secUD = '0;
      if (secZero && !minZero) begin
        if (minUQ == '0) begin
          minUD = 4'd9;
          minTD = minTQ - 1'b1;
        end else begin
          minUD = minUQ - 1'b1;
        end
      end
    end else if (strobes.tick && !(secZero && minZero)) begin
      if (secUQ != '0) begin
        secUD = secUQ - 1'b1;
      end else begin
        secUD = 4'd9;
        if (secTQ != '0) begin
          secTD = secTQ - 1'b1;
        end else begin
          secTD = 4'd5;
          if (minUQ == '0) begin
            minUD = 4'd9;
            minTD = minTQ - 1'b1;
          end else begin
            minUD = minUQ - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      minTQ <= '0;
      minUQ <= '0;
      secTQ <= '0;
      secUQ <= '0;
    end else begin
      minTQ <= minTD;
      minUQ <= minUD;
      secTQ <= secTD;
      secUQ <= secUD;
    end
  end

  assign minTens  = minTQ;
  assign minUnits = minUQ;
  assign secTens  = secTQ;
  assign secUnits = secUQ;

  // R11: digits legal
  p_digits_legal_r11: assert property (@(posedge clk) disable iff (rst)
    (secTQ <= 4'd5) && (secUQ <= 4'd9) && (minUQ <= 4'd9) &&
    ((32'(minTQ) * 10 + 32'(minUQ)) <= MAX_MINUTES));

  // R7: zero holds under ticks
  p_zero_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.tick && secZero && minZero) |=> (secZero && minZero));

  // R5: any step leaves the seconds at 00
  p_step_clears_sec_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.stepUp || strobes.stepDown) |=> secZero);

  // R3: ceiling saturates
  p_up_cap_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.stepUp && atMax) |=> atMax);

  // R4: floor saturates
  p_down_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.stepDown && minZero && secZero) |=> (minZero && secZero));

  // R8: no strobe, no change
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (strobes == '0) |=> ($stable(minTQ) && $stable(minUQ) && $stable(secTQ) && $stable(secUQ)));

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import ctimer_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_MINUTES = 60
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               btnCentreRaw,
  input  logic               btnUpRaw,
  input  logic               btnDownRaw,
  output logic [DIGIT_W-1:0] minTens,
  output logic [DIGIT_W-1:0] minUnits,
  output logic [DIGIT_W-1:0] secTens,
  output logic [DIGIT_W-1:0] secUnits,
  output logic               modeGo,
  output logic               dpMinUnits
);

  localparam int unsigned N_BTN = 3;

  logic [N_BTN-1:0] rawVec;
  logic [N_BTN-1:0] edgeVec;
  logic             tickPulse;
  ctrlStrobes_t     strobes;

  assign rawVec = {btnDownRaw, btnUpRaw, btnCentreRaw};

  generate
    for (genvar g = 0; g < N_BTN; g++) begin : g_btn
      ctimer_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .rawIn    (rawVec[g]),
        .pressEdge(edgeVec[g])
      );
    end
  endgenerate

  ctimer_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .enable   (modeGo),
    .tickPulse(tickPulse)
  );

  ctimer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .centreEdge(edgeVec[0]),
    .upEdge    (edgeVec[1]),
    .downEdge  (edgeVec[2]),
    .tickPulse (tickPulse),
    .strobes   (strobes),
    .modeGo    (modeGo)
  );

  ctimer_datapath #(.MAX_MINUTES(MAX_MINUTES)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .minTens (minTens),
    .minUnits(minUnits),
    .secTens (secTens),
    .secUnits(secUnits)
  );

  // minutes and seconds are separated by the point after the minutes units digit (R12)
  assign dpMinUnits = 1'b1;

endmodule

// File: tb/sim_countdown_timer.sv
module sim_countdown_timer;

  localparam int TDIV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cRaw = 1'b0, uRaw = 1'b0, dRaw = 1'b0;
  logic [3:0] minT, minU, secT, secU;
  logic modeGo, dp;

  int nChecks = 0;
  int nFails  = 0;
  int expSec  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  countdown_timer #(.TICK_DIV(TDIV), .SYNC_STAGES(2), .MAX_MINUTES(60)) u0 (
    .clk(clk), .rst(rst),
    .btnCentreRaw(cRaw), .btnUpRaw(uRaw), .btnDownRaw(dRaw),
    .minTens(minT), .minUnits(minU), .secTens(secT), .secUnits(secU),
    .modeGo(modeGo), .dpMinUnits(dp)
  );

  function automatic logic [15:0] toDigits(input int t);
    int m, s;
    m = t / 60;
    s = t % 60;
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic checkTime(input string req);
    nChecks++;
    if ({minT, minU, secT, secU} !== toDigits(expSec)) begin
      nFails++;
      $display("FAIL %s: time act=%h exp=%h", req, {minT, minU, secT, secU}, toDigits(expSec));
    end
  endtask

  task automatic checkMode(input string req, input logic expGo);
    nChecks++;
    if (modeGo !== expGo) begin
      nFails++;
      $display("FAIL %s: modeGo act=%b exp=%b", req, modeGo, expGo);
    end
  endtask

  // raw high at a falling edge; result due on the third rising edge after
  task automatic press(input int which);
    if (which == 0) cRaw = 1'b1; else if (which == 1) uRaw = 1'b1; else dRaw = 1'b1;
    repeat (3) @(negedge clk);
    cRaw = 1'b0; uRaw = 1'b0; dRaw = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count n ticks from the moment GO was entered or from the last tick
  task automatic runTicks(input int n, input bit inject);
    for (int k = 0; k < n; k++) begin
      if (inject && k == 2) uRaw = 1'b1;
      if (inject && k == 4) dRaw = 1'b1;
      repeat (TDIV - 1) @(negedge clk);
      uRaw = 1'b0;
      dRaw = 1'b0;
      checkTime(inject ? "R9 value before tick" : "R6 value before tick");
      @(negedge clk);
      if (expSec > 0) expSec--;
      checkTime(inject ? "R9 tick with ignored buttons" : "R6 tick decrement");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    checkTime("R1 reset time");
    checkMode("R1 reset mode", 1'b0);
    nChecks++;
    if (dp !== 1'b1) begin nFails++; $display("FAIL R12: dp act=%b exp=1", dp); end

    // R3 sweep upward with ceiling
    for (int i = 1; i <= 62; i++) begin
      press(1);
      expSec = (i > 60 ? 60 : i) * 60;
      checkTime("R3 minute up step");
      idle(2);
    end

    // R2 into GO, R6 borrow from 60:00
    press(0);
    checkMode("R2 enter GO", 1'b1);
    runTicks(3, 1'b0);
    press(0);
    checkMode("R2 enter SET", 1'b0);
    idle(10);
    checkTime("R8 paused value held");

    // R5 down with nonzero seconds
    press(2);
    expSec = 59 * 60;
    checkTime("R5 round down");
    idle(2);

    // R4 sweep downward with floor
    for (int i = 58; i >= -2; i--) begin
      press(2);
      expSec = (i < 0 ? 0 : i) * 60;
      checkTime("R4 minute down step");
      idle(2);
    end

    press(1); idle(2);
    press(1); expSec = 120; checkTime("R3 up from zero"); idle(2);

    // R9 presses ignored while counting
    press(0);
    checkMode("R2 enter GO", 1'b1);
    runTicks(7, 1'b1);
    press(0);
    checkMode("R2 pause", 1'b0);
    idle(20);
    checkTime("R8 held through pause");

    // R5 round up
    press(1);
    expSec = 120;
    checkTime("R5 round up");
    idle(2);

    // R8 resume continues
    press(0);
    runTicks(7, 1'b0);
    press(0);
    idle(4);
    press(2);
    expSec = 60;
    checkTime("R5 round down to whole minute");
    idle(2);

    // R7 count to zero and hold
    press(0);
    checkMode("R8 resume", 1'b1);
    runTicks(60, 1'b0);
    idle(3 * TDIV);
    checkTime("R7 hold at zero");

    // R10 long hold counts once
    press(0);
    checkMode("R2 back to SET", 1'b0);
    uRaw = 1'b1;
    idle(15);
    uRaw = 1'b0;
    idle(5);
    expSec = 60;
    checkTime("R10 long hold single step");

    nChecks++;
    if (dp !== 1'b1) begin nFails++; $display("FAIL R12: dp act=%b exp=1", dp); end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule